// File: doc/BRIEF.md
# Conversion Clock Sequencer with Automatic Power-Down

This block times analog-to-digital conversions. It runs on the chip's system clock and sees two single-cycle enable pulses: one that marks each period of an on-chip oscillator and one that marks each rising edge of the serial interface clock. A source-select input picks which of the two paces the conversion. When the serial clock is picked, its edges first pass through a prescaler that divides them by 1, 2 or 4. One conversion lasts exactly fourteen conversion-clock periods. While it runs, `busy` is high. At the end, `done` pulses for one cycle.

Power is managed without any setting. Whenever chip select is inactive, no start is requested and no conversion is running, the converter core enable drops. Any access raises it again by the next cycle. The reference enable stays on after reset, even while the core is powered down, so that the core can resume quickly.

The source and divider are captured in the cycle that a start is accepted. They are then held until that conversion ends. A start that arrives during a conversion has no effect.

Top module: `convclk_pwr`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy`, `done`, `core_pwr_en` and `ref_en` are all low.
- R2: From the first cycle after reset is released, `ref_en` is high in every cycle, including cycles where `core_pwr_en` is low.
- R3: A `start` pulse seen while `busy` is low makes `busy` high in the next cycle.
- R4: With `src_sel`=0 (oscillator), the conversion ends on the clock edge that samples the 14th `osc_tick` after the start cycle. In the following cycle `done` is high for exactly one cycle and `busy` is low.
- R5: With `src_sel`=1 (serial clock), the conversion ends on the edge that samples `sclk_rise` pulse number 14×N after the start cycle. N is 1 for `div_sel`=00, 2 for 01 and 4 for 10.
- R6: The code `div_sel`=11 divides by 4, the same as 10.
- R7: A `start` pulse while `busy` is high is ignored: the running conversion keeps its timing, and `busy` stays low after its `done`.
- R8: `src_sel` and `div_sel` are sampled in the start cycle. Changes to them while `busy` is high do not alter the conversion's length.
- R9: `core_pwr_en` is high in the cycle after any cycle with `cs_act` or `start` high, and in every cycle where `busy` is high. It is low in the cycle after a cycle with `cs_act` low, `start` low and `busy` low.
- R10: Pulses of the source that is not selected do not advance the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| sclk_rise | input | 1 | One-cycle pulse per serial-clock rising edge |
| src_sel | input | 1 | Conversion clock source: 0 oscillator, 1 serial clock |
| div_sel | input | 2 | Serial-clock divide code: 00 /1, 01 /2, 10 /4, 11 /4 |
| cs_act | input | 1 | Chip select, high while the device is accessed |
| start | input | 1 | Conversion start request |
| core_pwr_en | output | 1 | Converter core power enable |
| ref_en | output | 1 | Reference enable |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when a conversion ends |

## Verification
The assertions check, on every cycle, the rules that tie signals together:
- `done` is a single-cycle pulse that coincides with `busy` falling.
- An accepted start raises `busy`.
- The core is powered whenever it is busy or was accessed in the previous cycle, and is powered down after an idle cycle.
- The reference stays enabled.

Only the bench's scenarios can show the conversion length. That means the exact count of 14 conversion clocks, the 1/2/4 prescaling including the reserved code, that unselected pulses and late starts are ignored, and that configuration changes made mid-conversion are ignored. The bench predicts the ending edge for each pattern of pulses and compares it with where `done` appears.

// File: rtl/convclk_pkg.sv
package convclk_pkg;

    // Number of conversion-clock periods in one conversion
    localparam int CONV_CLKS = 14;
    // Width of the serial-clock divide code and prescale counter
    localparam int DIV_W     = 2;
    localparam int PRE_W     = 2;

    typedef enum logic {
        SRC_OSC  = 1'b0,
        SRC_SCLK = 1'b1
    } clk_src_e;

    typedef struct packed {
        clk_src_e           src;
        logic [DIV_W-1:0]   div;
    } conv_cfg_t;

    // Terminal prescale count for a divide code; the reserved code acts as /4
    function automatic logic [PRE_W-1:0] pre_last(input logic [DIV_W-1:0] code);
        case (code)
            2'b00:   pre_last = PRE_W'(0);
            2'b01:   pre_last = PRE_W'(1);
            default: pre_last = PRE_W'(3);
        endcase
    endfunction

endpackage

// File: rtl/cc_cfg_hold.sv
module cc_cfg_hold
    import convclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       busy,
    input  conv_cfg_t  cfg_in,
    output conv_cfg_t  cfg_q
);
    // Follows the inputs while idle, frozen for the length of a conversion
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{src: SRC_OSC, div: '0};
        end else if (!busy) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/cc_tick_gen.sv
module cc_tick_gen
    import convclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       busy,
    input  conv_cfg_t  cfg,
    input  logic       osc_tick,
    input  logic       sclk_rise,
    output logic       conv_tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_end;
    logic             pre_wrap;

    assign pre_end  = pre_last(cfg.div);
    assign pre_wrap = sclk_rise && (pre_q == pre_end);

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            pre_q <= '0;
        end else if (cfg.src == SRC_SCLK && sclk_rise) begin
            pre_q <= pre_wrap ? '0 : pre_q + PRE_W'(1);
        end
    end

    always_comb begin
        if (!busy)
            conv_tick = 1'b0;
        else if (cfg.src == SRC_OSC)
            conv_tick = osc_tick;
        else
            conv_tick = pre_wrap;
    end
endmodule

// File: rtl/cc_conv_seq.sv
module cc_conv_seq #(
    parameter int N_CLKS = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic conv_tick,
    output logic busy,
    output logic busy_nxt,
    output logic done
);
    localparam int CW = (N_CLKS > 1) ? $clog2(N_CLKS) : 1;

    logic [CW-1:0] cnt_q;
    logic          last_tick;

    assign last_tick = busy && conv_tick && (cnt_q == CW'(N_CLKS - 1));

    always_comb begin
        if (!busy)
            busy_nxt = start;
        else
            busy_nxt = !last_tick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
        end else begin
            busy <= busy_nxt;
            done <= last_tick;
            if (!busy || last_tick)
                cnt_q <= '0;
            else if (conv_tick)
                cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/cc_power.sv
module cc_power (
    input  logic clk,
    input  logic rst,
    input  logic cs_act,
    input  logic start,
    input  logic busy_nxt,
    output logic core_pwr_en,
    output logic ref_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            core_pwr_en <= 1'b0;
            ref_en      <= 1'b0;
        end else begin
            core_pwr_en <= cs_act || start || busy_nxt;
            ref_en      <= 1'b1;
        end
    end
endmodule

// File: rtl/convclk_pwr.sv
module convclk_pwr
    import convclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             sclk_rise,
    input  logic             src_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             cs_act,
    input  logic             start,
    output logic             core_pwr_en,
    output logic             ref_en,
    output logic             busy,
    output logic             done
);
    conv_cfg_t cfg_in;
    conv_cfg_t cfg_q;
    logic      conv_tick;
    logic      busy_nxt;

    assign cfg_in.src = clk_src_e'(src_sel);
    assign cfg_in.div = div_sel;

    cc_cfg_hold u_cfg (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    cc_tick_gen u_tick (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .cfg       (cfg_q),
        .osc_tick  (osc_tick),
        .sclk_rise (sclk_rise),
        .conv_tick (conv_tick)
    );

    cc_conv_seq #(.N_CLKS(CONV_CLKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .conv_tick (conv_tick),
        .busy      (busy),
        .busy_nxt  (busy_nxt),
        .done      (done)
    );

    cc_power u_pwr (
        .clk         (clk),
        .rst         (rst),
        .cs_act      (cs_act),
        .start       (start),
        .busy_nxt    (busy_nxt),
        .core_pwr_en (core_pwr_en),
        .ref_en      (ref_en)
    );
endmodule

// File: rtl/convclk_pwr_chk.sv
module convclk_pwr_chk (
    input logic clk,
    input logic rst,
    input logic cs_act,
    input logic start,
    input logic core_pwr_en,
    input logic ref_en,
    input logic busy,
    input logic done
);
    // High once at least one non-reset edge has passed
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    p_ref_on_r2: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ref_en);

    p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_busy_pwr_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> core_pwr_en);

    p_access_pwr_r9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(cs_act || start)) |-> core_pwr_en);

    p_idle_pwr_r9: assert property (@(posedge clk) disable iff (rst)
        (!cs_act && !start && !busy) |=> !core_pwr_en);
endmodule

bind convclk_pwr convclk_pwr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_act      (cs_act),
    .start       (start),
    .core_pwr_en (core_pwr_en),
    .ref_en      (ref_en),
    .busy        (busy),
    .done        (done)
);

// File: tb/convclk_pwr_bench.sv
`timescale 1ns/1ps
module convclk_pwr_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       sclk_rise = 1'b0;
    logic       src_sel = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       cs_act = 1'b0;
    logic       start = 1'b0;
    logic       core_pwr_en, ref_en, busy, done;

    int unsigned cyc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    int unsigned exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    convclk_pwr u_convclk_pwr (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .sclk_rise(sclk_rise),
        .src_sel(src_sel), .div_sel(div_sel), .cs_act(cs_act), .start(start),
        .core_pwr_en(core_pwr_en), .ref_en(ref_en), .busy(busy), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Monitor: every done pulse must match the next predicted ending edge
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                n_vec++;
                n_bad++;
                $display("FAIL R7: actual done at %0d expected none", cyc);
            end else begin
                check(tag_q.pop_front(), int'(cyc), int'(exp_q.pop_front()));
            end
        end
    end

    // Driver: one conversion with a given source, divider and pulse spacing.
    // noise pulses the unselected source; poke restarts and reconfigures mid-way.
    task automatic run_conv(input bit src, input logic [1:0] div, input int gap,
                            input bit noise, input bit poke, input string tag);
        int mult = (div == 2'b00) ? 1 : (div == 2'b01) ? 2 : 4;
        int n    = src ? 14 * mult : 14;
        @(negedge clk);
        src_sel = src;
        div_sel = div;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R3 busy after start", busy, 1);
        check("R9 power while busy", core_pwr_en, 1);
        for (int i = 0; i < n; i++) begin
            repeat (gap) @(negedge clk);
            if (src) begin
                sclk_rise = 1'b1;
                osc_tick  = noise;
            end else begin
                osc_tick  = 1'b1;
                sclk_rise = noise;
            end
            if (poke && i == 3) begin
                start   = 1'b1;
                src_sel = ~src;
                div_sel = 2'b00;
            end
            if (i == n - 1) begin
                exp_q.push_back(cyc + 1);
                tag_q.push_back(tag);
            end
            @(negedge clk);
            osc_tick  = 1'b0;
            sclk_rise = 1'b0;
            start     = 1'b0;
            if (i == n - 2) check("R9 power while busy", core_pwr_en, 1);
        end
        check({tag, " done"}, done, 1);
        check({tag, " busy low at done"}, busy, 0);
        @(negedge clk);
        check("R4 done one cycle", done, 0);
        check("R9 idle powers down", core_pwr_en, 0);
        check("R2 reference on while down", ref_en, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            check("R7 no restart after done", busy, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 0);
        check("R1 done in reset", done, 0);
        check("R1 pwr in reset", core_pwr_en, 0);
        check("R1 ref in reset", ref_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 ref after reset", ref_en, 1);
        check("R9 idle after reset", core_pwr_en, 0);
        check("R1 busy after reset", busy, 0);

        cs_act = 1'b1;
        @(negedge clk);
        check("R9 power on access", core_pwr_en, 1);
        cs_act = 1'b0;
        @(negedge clk);
        check("R9 power down idle", core_pwr_en, 0);
        check("R2 ref while down", ref_en, 1);

        run_conv(1'b0, 2'b00, 2, 1'b0, 1'b0, "R4 osc");
        run_conv(1'b0, 2'b10, 0, 1'b1, 1'b0, "R10 osc with sclk noise");
        run_conv(1'b1, 2'b00, 1, 1'b0, 1'b0, "R5 sclk div1");
        run_conv(1'b1, 2'b01, 0, 1'b0, 1'b0, "R5 sclk div2");
        run_conv(1'b1, 2'b10, 1, 1'b1, 1'b0, "R5 sclk div4");
        run_conv(1'b1, 2'b11, 0, 1'b0, 1'b0, "R6 reserved div");
        run_conv(1'b1, 2'b10, 2, 1'b0, 1'b1, "R8 cfg change ignored");
        run_conv(1'b0, 2'b01, 1, 1'b0, 1'b1, "R7 start while busy");

        repeat (4) @(negedge clk);
        check("R7 pending predictions", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule